// File: doc/BRIEF.md
# FIFO Counter Self-Test Controller with Split CRC Signatures

This block is a built-in self-test engine that sits beside one RAM/FIFO block. It is set up through a short serial control register. A start pulse, shared by many such engines on a chip, launches the test. Only engines whose control register has its arm bit set respond. The engine then exercises the FIFO read and write pointers over every depth the block can be configured to, from two words up to the full array. For each depth it fills the FIFO completely and then drains it.

The responses are not compared on chip. Three separate 16-bit CRC registers fold them into signatures: one takes the words read back from the RAM, one takes the FIFO status flags, and one takes the pointer values. When the walk ends, the engine drops busy and raises done. The three signatures are then held in an unload register and shifted out one bit at a time. An external tester compares them with precomputed values. The RAM array is not part of the block; it connects through a plain write/read port with one cycle of read latency.

Top module: `fifo_bist`

## Requirements
- R1: The control register is 3 bits wide and is loaded LSB first from `cfg_in`, one bit per cycle in which `cfg_shift` is high. After three shifts, bits [1:0] hold the data-pattern mode and bit 2 holds the arm flag.
- R2: A `start` pulse with the arm flag at 1 while the engine is idle makes `busy` high and `done` low from the next cycle. A `start` with the arm flag at 0, or a `start` while busy, has no effect.
- R3: The walk visits depths D = 2, 4, 8, up to 2^ADDR_W, in rising order. For each depth it makes D writes to addresses 0..D-1, then D reads from addresses 0..D-1, one operation per cycle, never writing and reading in the same cycle. `busy` stays high for exactly 2*(2^(ADDR_W+1)-2)+2 cycles.
- R4: The write data at address a depends on the mode. Mode 0 writes a, zero-extended. Mode 1 writes the bitwise inverse of that. Mode 2 writes a word whose bit i is 1 when (i even) XOR a[0]. Mode 3 writes a one-hot word with bit (a mod DATA_W) set.
- R5: The data signature takes every word returned by the RAM, in read order, where each word arrives one cycle after its read.
- R6: At each walk step, the flag signature takes the 4-bit word {full, afull, aempty, empty} computed from the occupancy n before that step. The flags are: full = (n==D), afull = (n>=D-1), aempty = (n<=1), empty = (n==0). No write happens when full and no read happens when empty.
- R7: At each walk step, the pointer signature takes {wptr, rptr} (wptr in the upper ADDR_W bits) as they stand before that step. Both pointers wrap modulo D and restart at 0 for each new depth.
- R8: Each signature uses the polynomial x^16+x^12+x^5+1 (0x1021). It is seeded to 0xFFFF when a test starts, and each input word is shifted in MSB first.
- R9: `busy` falls and `done` rises on the same edge. At that point the 48-bit word {pointer, flag, data} signature is loaded for unload. `sig_out` shows bit 0 of the data signature, and each cycle with `sig_shift` high advances it by one bit. `done` holds until the next accepted start.
- R10: `cfg_shift` is ignored while busy. The control register keeps its value, and the next run uses the configuration shifted in before the busy run.
- R11: A fault that corrupts stored data changes only the data signature. The flag and pointer signatures keep their fault-free values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Common test launch pulse |
| cfg_shift | input | 1 | Shift enable for the control register |
| cfg_in | input | 1 | Serial control data |
| sig_shift | input | 1 | Advance the signature unload by one bit |
| sig_out | output | 1 | Serial signature bit |
| busy | output | 1 | Test walk in progress |
| done | output | 1 | Signatures stable and ready to unload |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after ram_re |

## Verification
The assertions rely on three things about the environment. The RAM answers a read on the following cycle. `start` and `cfg_shift` may arrive at any time, including mid-run. The unload is only meaningful once `done` is high. The bench keeps to these conditions with a behavioural RAM of one-cycle latency. It launches runs in randomly chosen modes from a fixed seed, and on some runs it makes the RAM store corrupted data through a random XOR mask. In one directed run it deliberately shifts control bits and pulses `start` while busy. It reads signatures only after `done` is observed.

// File: rtl/bist_pkg.sv
`timescale 1ns/1ps
package bist_pkg;
  localparam int          SIG_BITS = 16;
  localparam logic [15:0] SIG_POLY = 16'h1021;
  localparam logic [15:0] SIG_SEED = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_LOAD} walk_st_t;

  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
    logic empty;
  } fifo_flags_t;
endpackage

// File: rtl/bist_cfg.sv
`timescale 1ns/1ps
module bist_cfg #(
  parameter int CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  input  logic             hold,
  output logic [CFG_W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)                cfg <= '0;
    else if (shift && !hold) cfg <= {din, cfg[CFG_W-1:1]};
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cfg)); // R10
endmodule

// File: rtl/bist_crc.sv
`timescale 1ns/1ps
module bist_crc
  import bist_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init,
  input  logic                en,
  input  logic [IN_W-1:0]     din,
  output logic [SIG_BITS-1:0] sig
);
  function automatic logic [SIG_BITS-1:0] fold(input logic [SIG_BITS-1:0] c,
                                                input logic [IN_W-1:0] d);
    logic [SIG_BITS-1:0] r;
    logic fb;
    r = c;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = r[SIG_BITS-1] ^ d[i];
      r  = {r[SIG_BITS-2:0], 1'b0};
      if (fb) r = r ^ SIG_POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || init) sig <= SIG_SEED;
    else if (en)     sig <= fold(sig, din);
  end

  AST_SEED_ON_INIT: assert property (@(posedge clk) disable iff (rst)
    init |=> (sig == SIG_SEED)); // R8
endmodule

// File: rtl/bist_unload.sv
`timescale 1ns/1ps
module bist_unload #(
  parameter int SIG_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic             hold,
  input  logic [SIG_W-1:0] din,
  output logic             sout
);
  logic [SIG_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)                 sr <= '0;
    else if (load)           sr <= din;
    else if (shift && !hold) sr <= {1'b0, sr[SIG_W-1:1]};
  end

  assign sout = sr[0];

  AST_UNLOAD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (hold && !load) |=> $stable(sr)); // R9
endmodule

// File: rtl/bist_walk.sv
`timescale 1ns/1ps
module bist_walk
  import bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [1:0]            mode,
  output logic                  busy,
  output logic                  done,
  output logic                  step_vld,
  output logic                  rd_vld,
  output logic                  load,
  output fifo_flags_t           flags,
  output logic [2*ADDR_W-1:0]   ptr_word,
  output logic                  ram_we,
  output logic                  ram_re,
  output logic [ADDR_W-1:0]     ram_addr,
  output logic [DATA_W-1:0]     ram_wdata
);
  localparam int KW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  walk_st_t          st;
  logic [KW-1:0]     lvl;
  logic              rd_ph;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [ADDR_W:0]   occ;
  logic [1:0]        mode_q;
  logic [ADDR_W:0]   depth;
  logic [ADDR_W-1:0] mask;

  function automatic logic [DATA_W-1:0] pattern(input logic [1:0] m,
                                                 input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] p;
    p = '0;
    case (m)
      2'd0: p = DATA_W'(a);
      2'd1: p = ~DATA_W'(a);
      2'd2: for (int i = 0; i < DATA_W; i++) p[i] = ((i % 2) == 0) ^ a[0];
      default: p = DATA_W'(1) << (a % DATA_W);
    endcase
    return p;
  endfunction

  assign depth     = (ADDR_W+1)'(2) << lvl;
  assign mask      = ADDR_W'(depth - (ADDR_W+1)'(1));
  assign busy      = (st != ST_IDLE);
  assign step_vld  = (st == ST_RUN);
  assign load      = (st == ST_LOAD);
  assign ram_we    = step_vld && !rd_ph;
  assign ram_re    = step_vld && rd_ph;
  assign ram_addr  = rd_ph ? rptr : wptr;
  assign ram_wdata = pattern(mode_q, wptr);
  assign ptr_word  = {wptr, rptr};

  always_comb begin
    flags.full   = (occ == depth);
    flags.afull  = (occ >= depth - (ADDR_W+1)'(1));
    flags.aempty = (occ <= (ADDR_W+1)'(1));
    flags.empty  = (occ == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; lvl <= '0; rd_ph <= 1'b0; wptr <= '0; rptr <= '0;
      occ <= '0; mode_q <= '0; done <= 1'b0; rd_vld <= 1'b0;
    end else begin
      rd_vld <= ram_re;
      case (st)
        ST_IDLE: if (go) begin
          st <= ST_RUN; lvl <= '0; rd_ph <= 1'b0; wptr <= '0; rptr <= '0;
          occ <= '0; mode_q <= mode; done <= 1'b0;
        end
        ST_RUN: if (!rd_ph) begin
          wptr <= (wptr + ADDR_W'(1)) & mask;
          occ  <= occ + (ADDR_W+1)'(1);
          if (wptr == mask) rd_ph <= 1'b1;
        end else begin
          rptr <= (rptr + ADDR_W'(1)) & mask;
          occ  <= occ - (ADDR_W+1)'(1);
          if (rptr == mask) begin
            rd_ph <= 1'b0;
            if (lvl == KW'(ADDR_W - 1)) st <= ST_DRAIN;
            else                        lvl <= lvl + KW'(1);
          end
        end
        ST_DRAIN: st <= ST_LOAD;
        default: begin st <= ST_IDLE; done <= 1'b1; end
      endcase
    end
  end

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re)); // R3
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !flags.full); // R6
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ram_re |-> !flags.empty); // R6
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    step_vld |-> (occ <= depth)); // R6
  AST_PTR_IN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    step_vld |-> ((wptr & ~mask) == '0 && (rptr & ~mask) == '0)); // R7
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy)); // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R9
endmodule

// File: rtl/fifo_bist.sv
`timescale 1ns/1ps
module fifo_bist
  import bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_shift,
  input  logic              cfg_in,
  input  logic              sig_shift,
  output logic              sig_out,
  output logic              busy,
  output logic              done,
  output logic              ram_we,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int CFG_W   = 3;
  localparam int PTR_W   = 2 * ADDR_W;
  localparam int FLAGS_W = $bits(fifo_flags_t);
  localparam int UNL_W   = 3 * SIG_BITS;

  logic [CFG_W-1:0]    cfg;
  logic                go, step_vld, rd_vld, load;
  fifo_flags_t         flags;
  logic [PTR_W-1:0]    ptr_word;
  logic [SIG_BITS-1:0] sig_data, sig_flag, sig_ptr;

  assign go = start && cfg[2] && !busy;

  bist_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .shift(cfg_shift), .din(cfg_in), .hold(busy), .cfg(cfg));

  bist_walk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
    .clk(clk), .rst(rst), .go(go), .mode(cfg[1:0]), .busy(busy), .done(done),
    .step_vld(step_vld), .rd_vld(rd_vld), .load(load), .flags(flags),
    .ptr_word(ptr_word), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  bist_crc #(.IN_W(DATA_W)) u_crc_data (
    .clk(clk), .rst(rst), .init(go), .en(rd_vld), .din(ram_rdata), .sig(sig_data));

  bist_crc #(.IN_W(FLAGS_W)) u_crc_flag (
    .clk(clk), .rst(rst), .init(go), .en(step_vld), .din(flags), .sig(sig_flag));

  bist_crc #(.IN_W(PTR_W)) u_crc_ptr (
    .clk(clk), .rst(rst), .init(go), .en(step_vld), .din(ptr_word), .sig(sig_ptr));

  bist_unload #(.SIG_W(UNL_W)) u_unload (
    .clk(clk), .rst(rst), .load(load), .shift(sig_shift), .hold(busy),
    .din({sig_ptr, sig_flag, sig_data}), .sout(sig_out));

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> busy); // R2
endmodule

// File: tb/sim_fifo_bist.sv
`timescale 1ns/1ps
module sim_fifo_bist;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int BUSY_LEN = 2 * ((2 << AW) - 2) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cfg_shift = 1'b0, cfg_in = 1'b0, sig_shift = 1'b0;
  logic sig_out, busy, done, ram_we, ram_re;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic [DW-1:0] fault = '0;
  logic [DW-1:0] mem [1 << AW];
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  fifo_bist #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_shift(cfg_shift), .cfg_in(cfg_in),
    .sig_shift(sig_shift), .sig_out(sig_out), .busy(busy), .done(done),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata ^ fault;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  function automatic logic [15:0] crc_in(input logic [15:0] c, input logic [31:0] d, input int w);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = w - 1; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input logic [1:0] m, input int a);
    logic [DW-1:0] p;
    p = '0;
    case (m)
      2'd0: p = DW'(a);
      2'd1: p = ~DW'(a);
      2'd2: for (int i = 0; i < DW; i++) p[i] = ((i % 2) == 0) ^ ((a % 2) == 1);
      default: p[a % DW] = 1'b1;
    endcase
    return p;
  endfunction

  function automatic logic [3:0] flg(input int n, input int d);
    return {n == d, n >= d - 1, n <= 1, n == 0};
  endfunction

  task automatic model(input logic [1:0] m, input logic [DW-1:0] fm,
                       output logic [15:0] ed, output logic [15:0] ef, output logic [15:0] ep);
    ed = 16'hFFFF; ef = 16'hFFFF; ep = 16'hFFFF;
    for (int k = 0; k < AW; k++) begin
      int d;
      d = 2 << k;
      for (int j = 0; j < d; j++) begin
        ef = crc_in(ef, 32'(flg(j, d)), 4);
        ep = crc_in(ep, 32'({AW'(j), AW'(0)}), 2 * AW);
      end
      for (int j = 0; j < d; j++) begin
        ef = crc_in(ef, 32'(flg(d - j, d)), 4);
        ep = crc_in(ep, 32'({AW'(0), AW'(j)}), 2 * AW);
        ed = crc_in(ed, 32'(pat(m, j) ^ fm), DW);
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_cfg(input logic [1:0] m, input logic arm);
    logic [2:0] b;
    b = {arm, m};
    for (int i = 0; i < 3; i++) begin
      cfg_in = b[i]; cfg_shift = 1'b1;
      @(negedge clk);
    end
    cfg_shift = 1'b0; cfg_in = 1'b0;
  endtask

  // disturb: shift mode 1 armed and pulse start while busy (R2, R10)
  task automatic run_test(input logic [1:0] m, input logic [DW-1:0] fm, input bit disturb);
    logic [2:0] db;
    logic [47:0] got;
    logic [15:0] ed, ef, ep;
    int cyc;
    db = 3'b101;
    fault = fm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 start accepted", {46'd0, busy, done}, 48'd2);
    cyc = 1;
    while (busy && cyc < 1000) begin
      if (disturb && cyc >= 10 && cyc < 13) begin
        cfg_shift = 1'b1; cfg_in = db[cyc - 10]; start = (cyc == 10);
      end else begin
        cfg_shift = 1'b0; cfg_in = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      if (busy) cyc++;
    end
    cfg_shift = 1'b0; start = 1'b0;
    chk(cyc == BUSY_LEN, "R3 busy length", 48'(cyc), 48'(BUSY_LEN));
    chk(done, "R9 done after walk", 48'(done), 48'd1);
    got = '0;
    sig_shift = 1'b1;
    for (int i = 0; i < 48; i++) begin
      got[i] = sig_out;
      @(negedge clk);
    end
    sig_shift = 1'b0;
    model(m, fm, ed, ef, ep);
    chk(got[15:0] == ed, "R5 R4 R8 data signature", 48'(got[15:0]), 48'(ed));
    chk(got[31:16] == ef, "R6 flag signature", 48'(got[31:16]), 48'(ef));
    chk(got[47:32] == ep, "R7 R11 pointer signature", 48'(got[47:32]), 48'(ep));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sig_out && !ram_we && !ram_re, "R2 R9 reset state",
        {43'd0, busy, done, sig_out, ram_we, ram_re}, 48'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R4: every mode, directed
    for (int m = 0; m < 4; m++) begin
      shift_cfg(2'(m), 1'b1);
      run_test(2'(m), '0, 1'b0);
    end

    // R2: start with arm cleared is ignored
    shift_cfg(2'd1, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && done, "R2 unarmed start ignored", {46'd0, busy, done}, 48'd1);

    // R10 R2: disturbance while busy, then rerun without new config
    shift_cfg(2'd2, 1'b1);
    run_test(2'd2, '0, 1'b1);
    run_test(2'd2, '0, 1'b0);

    // R11 and random modes with optional data faults
    for (int r = 0; r < 6; r++) begin
      logic [1:0] m;
      logic [DW-1:0] fm;
      m  = 2'($urandom_range(3, 0));
      fm = (r % 2 == 1) ? DW'($urandom_range(255, 1)) : '0;
      shift_cfg(m, 1'b1);
      run_test(m, fm, 1'b0);
    end
    fault = '0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule